// File: doc/BRIEF.md
# Display Window Word-Address Generator

This block produces the sequence of 32-bit word addresses needed to fetch a rectangular display window from a frame buffer. The frame buffer may be wider than the window. Software supplies a start address, a line length and a frame length (both in words), and a stride. The stride is the word-address step taken from the final word of one line to the first word of the next line. A mode bit turns this two-dimensional walk on. With the mode bit off, the stride is ignored and the frame is read as one contiguous run of words.

Configuration is written into shadow registers. Settings are copied into shadow only in a cycle where the update strobe is high. The shadow contents are moved into the active set only when the generator sits at the start of a frame. A frame is therefore never fetched with a mix of old and new settings, and the window can be moved between frames.

Addresses leave on a valid/ready stream:
- An address is consumed only in a cycle where both valid and ready are high.
- While ready is low, the address and its flags are held steady.
- Valid never drops without a transfer, except in one case: an update request lands while the first word of a frame is still waiting. In that case the pending settings take over before that word is taken.

A configuration checker reports illegal settings for 24-bit packed pixels.

Top module: `disp2d_addr_gen`

## Requirements
- R1: After reset, the active frame length is zero, 2D mode is off, `addr_valid` is low and `cfg_err` is low.
- R2: Changes to the `cfg_*` inputs have no effect on the outputs unless `upd_req` is high in some cycle.
- R3: A pending update is moved into the active set only while the generator is at a frame start. This means after reset, or after the last word of a frame has been consumed. In that load cycle `addr_valid` is low. The first address after the load is the new start address. Words of a frame already under way keep the old settings.
- R4: With 2D mode off, each accepted non-final word is followed by the address plus one, whatever the stride value.
- R5: With 2D mode on, after accepting the last word of a line (line word index equal to line length minus one) that is not the last of the frame, the next address is the old address plus the stride. Otherwise it is plus one.
- R6: `addr_last_frame` is high on word number frame-length-minus-one. `addr_last_line` is high on each line's last word and also on the frame's last word. After the final word is consumed, the address returns to the active start address.
- R7: A transfer occurs only when `addr_valid` and `addr_ready` are both high. With ready low, the address and flags hold.
- R8: Address arithmetic wraps modulo 2^32.
- R9: When 24-bit packed mode is active, `cfg_err` is high if the pixel bit offset is neither 0 nor 8. Outside packed mode, `cfg_err` is low.
- R10: When 24-bit packed mode is active, `cfg_err` is high if the window origin x modulo 4 is neither 0 nor 3. This allows origins 0, 3, 4, 7, 8 and so on.
- R11: While the active frame length is zero, `addr_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_base | input | 32 | Window start word address |
| cfg_pix_off | input | 5 | Bit offset of first pixel in first word |
| cfg_origin_x | input | 12 | Horizontal window origin in pixels |
| cfg_line_words | input | 16 | Words per window line (at least 1) |
| cfg_frame_words | input | 16 | Words per frame (0 stops fetching) |
| cfg_stride | input | 32 | Word step from a line's last word to the next line's first word |
| cfg_2d_en | input | 1 | 2D walk enable |
| cfg_pack24 | input | 1 | 24-bit packed pixel mode |
| upd_req | input | 1 | Copy `cfg_*` into shadow and mark an update pending |
| addr_valid | output | 1 | Address available |
| addr_ready | input | 1 | Consumer accepts the address |
| addr | output | 32 | Current word address |
| addr_last_line | output | 1 | Current word ends a line |
| addr_last_frame | output | 1 | Current word ends the frame |
| cfg_err | output | 1 | Active settings break 24-bit packed rules |

## Verification
All outputs are driven from registers. A transfer at one rising edge therefore shows its next address and flags at once after that edge. An `upd_req` raised at an edge is seen in the shadow on that edge. If the generator is at a frame start, that edge is followed by one load cycle with valid low. The active set and `cfg_err` change at the next edge. The bench drives inputs on the falling edge and advances its own model at each rising edge using the inputs it just drove. It compares every output on the following falling edge, so each result is checked in the first cycle in which it is due.

// File: rtl/disp2d_pkg.sv
package disp2d_pkg;
  typedef enum logic [1:0] {
    STEP_NEXT   = 2'd0,
    STEP_STRIDE = 2'd1,
    STEP_RELOAD = 2'd2
  } step_e;

  // 24-bit packed origins must sit at 4n or 4n-1 (i.e. mod 4 is 0 or 3)
  function automatic logic origin_ok(input logic [1:0] lsb);
    return (lsb == 2'd0) || (lsb == 2'd3);
  endfunction
endpackage

// File: rtl/disp2d_shadow.sv
module disp2d_shadow #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int XW = 12,
  parameter int OW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_base,
  input  logic [OW-1:0] cfg_pix_off,
  input  logic [XW-1:0] cfg_origin_x,
  input  logic [CW-1:0] cfg_line_words,
  input  logic [CW-1:0] cfg_frame_words,
  input  logic [AW-1:0] cfg_stride,
  input  logic          cfg_2d_en,
  input  logic          cfg_pack24,
  input  logic          upd_req,
  input  logic          at_start,
  output logic          load,
  output logic          pend,
  output logic [AW-1:0] ld_base,
  output logic [AW-1:0] act_base,
  output logic [OW-1:0] act_pix_off,
  output logic [XW-1:0] act_origin_x,
  output logic [CW-1:0] act_line,
  output logic [CW-1:0] act_frame,
  output logic [AW-1:0] act_stride,
  output logic          act_2d,
  output logic          act_pack24
);
  logic [AW-1:0] sh_base, sh_stride;
  logic [OW-1:0] sh_off;
  logic [XW-1:0] sh_x;
  logic [CW-1:0] sh_line, sh_frame;
  logic          sh_2d, sh_pack;

  assign load    = at_start & pend;
  assign ld_base = sh_base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_base <= '0; sh_stride <= '0; sh_off <= '0; sh_x <= '0;
      sh_line <= '0; sh_frame <= '0; sh_2d <= 1'b0; sh_pack <= 1'b0;
    end else if (upd_req) begin
      sh_base   <= cfg_base;
      sh_stride <= cfg_stride;
      sh_off    <= cfg_pix_off;
      sh_x      <= cfg_origin_x;
      sh_line   <= cfg_line_words;
      sh_frame  <= cfg_frame_words;
      sh_2d     <= cfg_2d_en;
      sh_pack   <= cfg_pack24;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_base <= '0; act_stride <= '0; act_pix_off <= '0; act_origin_x <= '0;
      act_line <= '0; act_frame <= '0; act_2d <= 1'b0; act_pack24 <= 1'b0;
    end else if (load) begin
      act_base     <= sh_base;
      act_stride   <= sh_stride;
      act_pix_off  <= sh_off;
      act_origin_x <= sh_x;
      act_line     <= sh_line;
      act_frame    <= sh_frame;
      act_2d       <= sh_2d;
      act_pack24   <= sh_pack;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= upd_req | (pend & ~load);
  end
endmodule

// File: rtl/disp2d_cfg_check.sv
module disp2d_cfg_check #(
  parameter int XW = 12,
  parameter int OW = 5
) (
  input  logic          pack24,
  input  logic [OW-1:0] pix_off,
  input  logic [XW-1:0] origin_x,
  output logic          err
);
  import disp2d_pkg::*;
  localparam logic [OW-1:0] OFF_B0 = OW'(0);
  localparam logic [OW-1:0] OFF_B8 = OW'(8);
  logic off_bad, org_bad;

  always_comb begin
    off_bad = (pix_off != OFF_B0) && (pix_off != OFF_B8);
    org_bad = !origin_ok(origin_x[1:0]);
    err     = pack24 && (off_bad || org_bad);
  end
endmodule

// File: rtl/disp2d_walk.sv
module disp2d_walk #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] ld_base,
  input  logic [AW-1:0] act_base,
  input  logic [CW-1:0] act_line,
  input  logic [CW-1:0] act_frame,
  input  logic [AW-1:0] act_stride,
  input  logic          act_2d,
  input  logic          ready,
  output logic          valid,
  output logic [AW-1:0] addr,
  output logic          last_line,
  output logic          last_frame,
  output logic          at_start
);
  import disp2d_pkg::*;
  localparam logic [CW-1:0] ONE_C = CW'(1);
  localparam logic [AW-1:0] ONE_A = AW'(1);

  logic [CW-1:0] wc, lc;
  logic          line_end, fire;
  step_e         step;

  always_comb begin
    valid      = (act_frame != '0) && !load;
    last_frame = (wc == act_frame - ONE_C);
    line_end   = (lc == act_line - ONE_C);
    last_line  = line_end || last_frame;
    fire       = valid && ready;
    if (last_frame)              step = STEP_RELOAD;
    else if (act_2d && line_end) step = STEP_STRIDE;
    else                         step = STEP_NEXT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0; wc <= '0; lc <= '0; at_start <= 1'b1;
    end else if (load) begin
      addr <= ld_base; wc <= '0; lc <= '0; at_start <= 1'b1;
    end else if (fire) begin
      unique case (step)
        STEP_RELOAD: begin
          addr <= act_base; wc <= '0; lc <= '0; at_start <= 1'b1;
        end
        STEP_STRIDE: begin
          addr <= addr + act_stride; wc <= wc + ONE_C; lc <= '0; at_start <= 1'b0;
        end
        default: begin
          addr     <= addr + ONE_A;
          wc       <= wc + ONE_C;
          lc       <= line_end ? '0 : lc + ONE_C;
          at_start <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/disp2d_addr_gen.sv
module disp2d_addr_gen #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int XW = 12,
  parameter int OW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_base,
  input  logic [OW-1:0] cfg_pix_off,
  input  logic [XW-1:0] cfg_origin_x,
  input  logic [CW-1:0] cfg_line_words,
  input  logic [CW-1:0] cfg_frame_words,
  input  logic [AW-1:0] cfg_stride,
  input  logic          cfg_2d_en,
  input  logic          cfg_pack24,
  input  logic          upd_req,
  output logic          addr_valid,
  input  logic          addr_ready,
  output logic [AW-1:0] addr,
  output logic          addr_last_line,
  output logic          addr_last_frame,
  output logic          cfg_err
);
  logic          load, pend, at_start, act_2d, act_pack24;
  logic [AW-1:0] ld_base, act_base, act_stride;
  logic [OW-1:0] act_pix_off;
  logic [XW-1:0] act_origin_x;
  logic [CW-1:0] act_line, act_frame;

  disp2d_shadow #(.AW(AW), .CW(CW), .XW(XW), .OW(OW)) u_shadow (
    .clk, .rst_n, .cfg_base, .cfg_pix_off, .cfg_origin_x, .cfg_line_words,
    .cfg_frame_words, .cfg_stride, .cfg_2d_en, .cfg_pack24, .upd_req,
    .at_start, .load, .pend, .ld_base, .act_base, .act_pix_off, .act_origin_x,
    .act_line, .act_frame, .act_stride, .act_2d, .act_pack24
  );

  disp2d_walk #(.AW(AW), .CW(CW)) u_walk (
    .clk, .rst_n, .load, .ld_base, .act_base, .act_line, .act_frame,
    .act_stride, .act_2d, .ready(addr_ready), .valid(addr_valid), .addr,
    .last_line(addr_last_line), .last_frame(addr_last_frame), .at_start
  );

  disp2d_cfg_check #(.XW(XW), .OW(OW)) u_check (
    .pack24(act_pack24), .pix_off(act_pix_off), .origin_x(act_origin_x),
    .err(cfg_err)
  );
endmodule

// File: rtl/disp2d_addr_gen_chk.sv
module disp2d_addr_gen_chk #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          upd_req,
  input logic          addr_valid,
  input logic          addr_ready,
  input logic [AW-1:0] addr,
  input logic          addr_last_line,
  input logic          addr_last_frame,
  input logic          cfg_err,
  input logic          at_start,
  input logic          pend,
  input logic          act_2d,
  input logic          act_pack24,
  input logic [AW-1:0] act_base,
  input logic [AW-1:0] act_stride,
  input logic [CW-1:0] act_frame
);
  logic fire;
  assign fire = addr_valid && addr_ready;

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !addr_ready && !upd_req |=> addr_valid && $stable(addr)
      && $stable(addr_last_line) && $stable(addr_last_frame));

  a_r4_contig: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !act_2d && !addr_last_frame |=> addr == $past(addr) + 1);

  a_r5_stride: assert property (@(posedge clk) disable iff (!rst_n)
    fire && act_2d && addr_last_line && !addr_last_frame
      |=> addr == $past(addr) + $past(act_stride));

  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    fire && addr_last_frame |=> addr == $past(act_base));

  a_r6_frame_ends_line: assert property (@(posedge clk) disable iff (!rst_n)
    addr_last_frame |-> addr_last_line);

  a_r3_active_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !at_start |=> $stable(act_base) && $stable(act_stride) && $stable(act_frame));

  a_r3_load_gap: assert property (@(posedge clk) disable iff (!rst_n)
    at_start && pend |-> !addr_valid);

  a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
    act_frame == '0 |-> !addr_valid);

  a_r9_unpacked_ok: assert property (@(posedge clk) disable iff (!rst_n)
    !act_pack24 |-> !cfg_err);
endmodule

bind disp2d_addr_gen disp2d_addr_gen_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .upd_req(upd_req), .addr_valid(addr_valid),
  .addr_ready(addr_ready), .addr(addr), .addr_last_line(addr_last_line),
  .addr_last_frame(addr_last_frame), .cfg_err(cfg_err), .at_start(at_start),
  .pend(pend), .act_2d(act_2d), .act_pack24(act_pack24), .act_base(act_base),
  .act_stride(act_stride), .act_frame(act_frame)
);

// File: tb/disp2d_addr_gen_bench.sv
module disp2d_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_base = '0, cfg_stride = '0;
  logic [4:0]  cfg_pix_off = '0;
  logic [11:0] cfg_origin_x = '0;
  logic [15:0] cfg_line_words = '0, cfg_frame_words = '0;
  logic        cfg_2d_en = 1'b0, cfg_pack24 = 1'b0, upd_req = 1'b0, addr_ready = 1'b0;
  logic        addr_valid, addr_last_line, addr_last_frame, cfg_err;
  logic [31:0] addr;

  int total = 0, failed = 0;

  // bench model state
  logic [31:0] s_base = '0, s_stride = '0, m_base = '0, m_stride = '0, m_addr = '0;
  logic [4:0]  s_off = '0, m_off = '0;
  logic [11:0] s_x = '0, m_x = '0;
  logic [15:0] s_line = '0, s_frame = '0, m_line = '0, m_frame = '0, m_wc = '0, m_lc = '0;
  logic        s_2d = 0, s_pk = 0, m_2d = 0, m_pk = 0, m_pend = 0, m_at = 1;

  always #2 clk = ~clk;

  disp2d_addr_gen u_disp2d_addr_gen (
    .clk, .rst_n, .cfg_base, .cfg_pix_off, .cfg_origin_x, .cfg_line_words,
    .cfg_frame_words, .cfg_stride, .cfg_2d_en, .cfg_pack24, .upd_req,
    .addr_valid, .addr_ready, .addr, .addr_last_line, .addr_last_frame, .cfg_err
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic exp_err();
    logic off_bad = (m_off != 5'd0) && (m_off != 5'd8);
    logic org_bad = !((m_x[1:0] == 2'd0) || (m_x[1:0] == 2'd3));
    return m_pk && (off_bad || org_bad);
  endfunction

  function automatic logic exp_valid();
    return (m_frame != 16'd0) && !(m_at && m_pend);
  endfunction

  // check outputs at negedge, drive, advance model at posedge, return at negedge
  task automatic step(input logic rdy, input logic upd);
    logic ev, lf, ll, ld;
    ev = exp_valid();
    lf = (m_wc == m_frame - 16'd1);
    ll = (m_lc == m_line - 16'd1) || lf;
    chk(m_frame == 0 ? "R11 valid" : "R7 valid", {31'd0, addr_valid}, {31'd0, ev});
    chk(m_pk ? "R9/R10 err" : "R9 err", {31'd0, cfg_err}, {31'd0, exp_err()});
    if (ev) begin
      chk(m_2d ? "R5 addr" : "R4 addr", addr, m_addr);
      chk("R6 last_frame", {31'd0, addr_last_frame}, {31'd0, lf});
      chk("R6 last_line", {31'd0, addr_last_line}, {31'd0, ll});
    end
    addr_ready = rdy;
    upd_req = upd;
    @(posedge clk);
    ld = m_at && m_pend;
    if (ld) begin
      m_base = s_base; m_stride = s_stride; m_off = s_off; m_x = s_x;
      m_line = s_line; m_frame = s_frame; m_2d = s_2d; m_pk = s_pk;
      m_addr = s_base; m_wc = 0; m_lc = 0;
    end else if (ev && rdy) begin
      if (lf) begin
        m_addr = m_base; m_wc = 0; m_lc = 0; m_at = 1;
      end else begin
        m_at = 0; m_wc = m_wc + 16'd1;
        if (m_lc == m_line - 16'd1) begin
          m_lc = 0; m_addr = m_2d ? m_addr + m_stride : m_addr + 32'd1;
        end else begin
          m_lc = m_lc + 16'd1; m_addr = m_addr + 32'd1;
        end
      end
    end
    if (upd) begin
      s_base = cfg_base; s_stride = cfg_stride; s_off = cfg_pix_off; s_x = cfg_origin_x;
      s_line = cfg_line_words; s_frame = cfg_frame_words; s_2d = cfg_2d_en; s_pk = cfg_pack24;
    end
    m_pend = upd | (m_pend & !ld);
    @(negedge clk);
    upd_req = 1'b0;
  endtask

  task automatic setcfg(input logic [31:0] b, input logic [15:0] ln, input logic [15:0] fr,
                        input logic [31:0] st, input logic e2d, input logic pk,
                        input logic [4:0] off, input logic [11:0] x);
    cfg_base = b; cfg_line_words = ln; cfg_frame_words = fr; cfg_stride = st;
    cfg_2d_en = e2d; cfg_pack24 = pk; cfg_pix_off = off; cfg_origin_x = x;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failed++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 valid after reset", {31'd0, addr_valid}, 32'd0);
    chk("R1 err after reset", {31'd0, cfg_err}, 32'd0);

    // R2 config change without update has no effect
    setcfg(32'h100, 16'd3, 16'd6, 32'd50, 1'b0, 1'b1, 5'd3, 12'd1);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
    chk("R2 no update keeps idle", {31'd0, addr_valid}, 32'd0);
    chk("R2 no update keeps err low", {31'd0, cfg_err}, 32'd0);

    // R4 contiguous: stride ignored with 2D off
    setcfg(32'h100, 16'd3, 16'd6, 32'd50, 1'b0, 1'b0, 5'd0, 12'd0);
    step(1'b1, 1'b1);
    for (int i = 0; i < 14; i++) step(1'b1, 1'b0);

    // R3: update mid-frame only applies at next frame start
    setcfg(32'h1000, 16'd2, 16'd4, 32'd10, 1'b1, 1'b0, 5'd0, 12'd0);
    step(1'b0, 1'b1);
    while (!(m_at && !m_pend)) step(1'b1, 1'b0);
    chk("R3 new base at frame start", addr, 32'h1000);
    step(1'b1, 1'b0);
    chk("R5 second word", addr, 32'h1001);
    setcfg(32'h2000, 16'd2, 16'd4, 32'd10, 1'b1, 1'b0, 5'd0, 12'd0);
    step(1'b0, 1'b1);
    chk("R3 frame keeps old settings", addr, 32'h1001);
    step(1'b1, 1'b0);
    chk("R5 stride after line end", addr, 32'h100B);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    chk("R6 reload old base before load", addr, 32'h1000);
    chk("R3 load cycle valid low", {31'd0, addr_valid}, 32'd0);
    step(1'b1, 1'b0);
    chk("R3 new base after load", addr, 32'h2000);
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0);

    // R8 wrap modulo 2^32
    setcfg(32'hFFFF_FFFE, 16'd8, 16'd4, 32'd0, 1'b0, 1'b0, 5'd0, 12'd0);
    step(1'b1, 1'b1);
    while (!(m_at && !m_pend)) step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    chk("R8 wrap to zero", addr, 32'h0);

    // R9 / R10 packed-mode legality
    setcfg(32'h40, 16'd1, 16'd1, 32'd0, 1'b0, 1'b1, 5'd8, 12'd7);
    step(1'b1, 1'b1);
    while (!(m_at && !m_pend)) step(1'b1, 1'b0);
    chk("R10 origin 7 legal", {31'd0, cfg_err}, 32'd0);
    setcfg(32'h40, 16'd1, 16'd1, 32'd0, 1'b0, 1'b1, 5'd16, 12'd4);
    step(1'b1, 1'b1);
    while (!(m_at && !m_pend)) step(1'b1, 1'b0);
    chk("R9 offset 16 illegal", {31'd0, cfg_err}, 32'd1);
    setcfg(32'h40, 16'd1, 16'd1, 32'd0, 1'b0, 1'b1, 5'd0, 12'd6);
    step(1'b1, 1'b1);
    while (!(m_at && !m_pend)) step(1'b1, 1'b0);
    chk("R10 origin 6 illegal", {31'd0, cfg_err}, 32'd1);

    // R11 zero frame length
    setcfg(32'h40, 16'd1, 16'd0, 32'd0, 1'b0, 1'b0, 5'd0, 12'd0);
    step(1'b1, 1'b1);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
    chk("R11 zero frame idle", {31'd0, addr_valid}, 32'd0);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic u;
      u = ($urandom % 40) == 0;
      if (u) setcfg($urandom, 16'($urandom % 8 + 1), 16'($urandom % 30),
                    ($urandom % 2) ? 32'($urandom % 64) : $urandom,
                    1'($urandom), 1'($urandom), 5'($urandom), 12'($urandom));
      step(($urandom % 4) != 0, u);
    end

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule